// File: doc/BRIEF.md
# Banked Interrupt Control Unit

This block gathers interrupt requests from several identical banks of 32 sources each. In every bank a per-source status bit is set by its input. A mode bit picks whether a high level or a 0-to-1 transition sets it. Once set, the bit stays set until software clears it. An enable register gates the status bits into a masked view, and the OR of that masked view, held in a register, becomes one processor request line per bank. Bank k drives request line k.

Software reaches every bank through one simple 32-bit register port. The port always accepts a request, and a read returns its data one cycle after it is accepted. Each bank has five registers. A clear-by-ones status register and a set-by-ones register let software retire or inject requests. The bank also holds an enable mask, a read-only masked view and a mode word. Banks repeat at a fixed byte stride, so one address decode serves all of them.

Top module: `banked_icu`

## Requirements
- R1: After reset every status, enable and mode register reads as zero and every `irq_o` bit is low.
- R2: A source whose mode bit is 0 (level) sets its status bit in the cycle after its input is sampled high. The bit stays set after the input falls, until it is cleared by a write.
- R3: A source whose mode bit is 1 (edge) sets its status bit only when its input goes from 0 to 1. An input held high after a clear does not set the bit again.
- R4: Writing to bank offset 0x00 clears the status bits where the write data is 1 and leaves the others unchanged. A read of 0x00 returns the raw status.
- R5: When a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Offset 0x08 is a read/write enable mask. Offset 0x10 reads status AND enable, and writes to 0x10 have no effect.
- R7: Writing to offset 0x18 sets the status bits where the write data is 1. A read of 0x18 returns the raw status.
- R8: Offset 0x20 is a read/write per-source mode word, where bit i = 1 selects edge mode for source i.
- R9: Bank N occupies byte addresses N*0x28 plus the register offset. Source i of bank N is input bit N*32+i, and bank N drives `irq_o[N]`.
- R10: `irq_o[N]` equals the OR of bank N's masked status as it stood one cycle earlier.
- R11: A read of any address that matches no register returns zero, and a write to it changes no state. This covers offsets other than the five listed and addresses past the last bank.
- R12: `req_ready` is always high. Each accepted read raises `rsp_valid` for exactly the next cycle, with the data on `rsp_rdata`, and `rsp_valid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_BANKS*32 | Interrupt source inputs, bank-major |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted (always high) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | NUM_BANKS | Per-bank processor request lines |

## Verification
The hardest situation to create is a hardware set that lands on a status bit in the very cycle a clear-by-ones write hits it. Just as hard is an edge-mode input that stays high across a clear, where the bit must not come back. Directed sequences hold a level-mode input high while the clear write is on the bus, and hold an edge-mode input high across its clear before reading status back. A long random phase then mixes sparse input patterns, mode changes and accesses to mapped and unmapped addresses in all banks. Every read and every request line is checked against a bench model in every cycle.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned BANK_IDX_W = 4;
    localparam int unsigned STRIDE     = 40;   // 0x28 bytes per bank

    localparam int unsigned OFF_STAT   = 'h00;
    localparam int unsigned OFF_EN     = 'h08;
    localparam int unsigned OFF_MASKED = 'h10;
    localparam int unsigned OFF_SET    = 'h18;
    localparam int unsigned OFF_MODE   = 'h20;

    typedef enum logic [2:0] {
        SEL_STAT,
        SEL_EN,
        SEL_MASKED,
        SEL_SET,
        SEL_MODE,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic                  hit;
        logic [BANK_IDX_W-1:0] bank;
        reg_sel_e              sel;
    } dec_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input int unsigned nb);
        dec_t        d;
        int unsigned bk;
        int unsigned off;
        bk  = 32'(a) / STRIDE;
        off = 32'(a) % STRIDE;
        case (off)
            OFF_STAT:   d.sel = SEL_STAT;
            OFF_EN:     d.sel = SEL_EN;
            OFF_MASKED: d.sel = SEL_MASKED;
            OFF_SET:    d.sel = SEL_SET;
            OFF_MODE:   d.sel = SEL_MODE;
            default:    d.sel = SEL_NONE;
        endcase
        d.bank = bk[BANK_IDX_W-1:0];
        d.hit  = (bk < nb) && (d.sel != SEL_NONE);
        return d;
    endfunction

endpackage

// File: rtl/icu_decoder.sv
module icu_decoder
    import icu_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 5
) (
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    output dec_t                 dec_o,
    output logic [NUM_BANKS-1:0] wr_clr_o,
    output logic [NUM_BANKS-1:0] wr_en_o,
    output logic [NUM_BANKS-1:0] wr_set_o,
    output logic [NUM_BANKS-1:0] wr_mode_o
);

    dec_t dec;
    logic wr_ok;

    assign dec   = decode_addr(req_addr, NUM_BANKS);
    assign dec_o = dec;
    assign wr_ok = req_valid && req_write && dec.hit;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strobe
        logic mine;
        assign mine         = wr_ok && (dec.bank == BANK_IDX_W'(b));
        assign wr_clr_o[b]  = mine && (dec.sel == SEL_STAT);
        assign wr_en_o[b]   = mine && (dec.sel == SEL_EN);
        assign wr_set_o[b]  = mine && (dec.sel == SEL_SET);
        assign wr_mode_o[b] = mine && (dec.sel == SEL_MODE);
    end

endmodule

// File: rtl/icu_bank.sv
module icu_bank
    import icu_pkg::*;
#(
    parameter int unsigned SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src_i,
    input  logic             wr_clr_i,
    input  logic             wr_en_i,
    input  logic             wr_set_i,
    input  logic             wr_mode_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] stat_o,
    output logic [SRC_W-1:0] en_o,
    output logic [SRC_W-1:0] mode_o,
    output logic [SRC_W-1:0] masked_o,
    output logic             irq_o
);

    logic [SRC_W-1:0] stat_q, en_q, mode_q, in_q;
    logic [SRC_W-1:0] hw_set, clr_v, sw_set, stat_d;
    logic             irq_q;

    // per-source set condition chosen by its mode bit
    for (genvar i = 0; i < SRC_W; i++) begin : g_src
        assign hw_set[i] = mode_q[i] ? (src_i[i] & ~in_q[i]) : src_i[i];
    end

    assign clr_v  = wr_clr_i ? wdata_i : '0;
    assign sw_set = wr_set_i ? wdata_i : '0;
    assign stat_d = (stat_q & ~clr_v) | hw_set | sw_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= '0;
            mode_q <= '0;
            in_q   <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            in_q   <= src_i;
            irq_q  <= |(stat_q & en_q);
            if (wr_en_i)   en_q   <= wdata_i;
            if (wr_mode_i) mode_q <= wdata_i;
        end
    end

    assign stat_o   = stat_q;
    assign en_o     = en_q;
    assign mode_o   = mode_q;
    assign masked_o = stat_q & en_q;
    assign irq_o    = irq_q;

    // R2: a set bit that no write clears stays set
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(stat_q & ~clr_v)) == $past(stat_q & ~clr_v)));

    // R3: in edge mode a new bit needs a rising input or a software set
    p_edge_only_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & $past(mode_q & ~(src_i & ~in_q) & ~sw_set)) == '0));

    // R5: hardware set beats a same-cycle clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (|(hw_set & clr_v)) |=> ((stat_q & $past(hw_set & clr_v)) == $past(hw_set & clr_v)));

    // R10: nothing enabled pending means the request line drops next cycle
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & en_q) == '0) |=> !irq_o);

endmodule

// File: rtl/banked_icu.sv
module banked_icu
    import icu_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 5,
    parameter int unsigned SRC_W     = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_BANKS*SRC_W-1:0] src_i,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       req_ready,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic [NUM_BANKS-1:0]       irq_o
);

    dec_t                 dec;
    logic [NUM_BANKS-1:0] wr_clr, wr_en, wr_set, wr_mode;
    logic [SRC_W-1:0]     stat_a   [NUM_BANKS];
    logic [SRC_W-1:0]     en_a     [NUM_BANKS];
    logic [SRC_W-1:0]     mode_a   [NUM_BANKS];
    logic [SRC_W-1:0]     masked_a [NUM_BANKS];
    logic [DATA_W-1:0]    rd_mux;
    logic                 rd_req;

    icu_decoder #(.NUM_BANKS(NUM_BANKS)) dec_i (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .dec_o     (dec),
        .wr_clr_o  (wr_clr),
        .wr_en_o   (wr_en),
        .wr_set_o  (wr_set),
        .wr_mode_o (wr_mode)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        icu_bank #(.SRC_W(SRC_W)) bank_i (
            .clk       (clk),
            .rst       (rst),
            .src_i     (src_i[b*SRC_W +: SRC_W]),
            .wr_clr_i  (wr_clr[b]),
            .wr_en_i   (wr_en[b]),
            .wr_set_i  (wr_set[b]),
            .wr_mode_i (wr_mode[b]),
            .wdata_i   (req_wdata[SRC_W-1:0]),
            .stat_o    (stat_a[b]),
            .en_o      (en_a[b]),
            .mode_o    (mode_a[b]),
            .masked_o  (masked_a[b]),
            .irq_o     (irq_o[b])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec.hit && dec.bank == BANK_IDX_W'(b)) begin
                case (dec.sel)
                    SEL_STAT, SEL_SET: rd_mux = DATA_W'(stat_a[b]);
                    SEL_EN:            rd_mux = DATA_W'(en_a[b]);
                    SEL_MASKED:        rd_mux = DATA_W'(masked_a[b]);
                    SEL_MODE:          rd_mux = DATA_W'(mode_a[b]);
                    default:           rd_mux = '0;
                endcase
            end
        end
    end

    assign req_ready = 1'b1;
    assign rd_req    = req_valid && !req_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            if (rd_req) rsp_rdata <= rd_mux;
        end
    end

    // R12: one response cycle per accepted read, none otherwise
    p_rsp_after_read_r12: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rsp_valid);
    p_no_rsp_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rsp_valid);

    // R11: unmapped reads return zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !dec.hit) |=> (rsp_rdata == '0));

endmodule

// File: tb/banked_icu_tb_top.sv
module banked_icu_tb_top;

    localparam int NB = 5;
    localparam int W  = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic [NB*W-1:0] src;
    logic            req_valid, req_write;
    logic [7:0]      req_addr;
    logic [31:0]     req_wdata;
    logic            req_ready, rsp_valid;
    logic [31:0]     rsp_rdata;
    logic [NB-1:0]   irq;

    always #2 clk = ~clk;   // 250 MHz

    banked_icu #(.NUM_BANKS(NB), .SRC_W(W)) dut_i (
        .clk(clk), .rst(rst), .src_i(src),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .irq_o(irq)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_stat [NB];
    logic [31:0] m_en   [NB];
    logic [31:0] m_mode [NB];
    logic [31:0] m_prev [NB];
    logic        m_irq  [NB];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int bk  = int'(a) / 40;
        int off = int'(a) % 40;
        if (bk >= NB) return 32'h0;
        case (off)
            'h00, 'h18: return m_stat[bk];
            'h08:       return m_en[bk];
            'h10:       return m_stat[bk] & m_en[bk];
            'h20:       return m_mode[bk];
            default:    return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [7:0] a);
        int bk  = int'(a) / 40;
        int off = int'(a) % 40;
        if (bk >= NB) return "R11";
        case (off)
            'h00:    return "R4";
            'h08:    return "R6";
            'h10:    return "R6";
            'h18:    return "R7";
            'h20:    return "R8";
            default: return "R11";
        endcase
    endfunction

    // one clock: model step, edge, compare request lines at the falling edge
    task automatic cyc();
        logic [31:0] n_stat [NB];
        logic [31:0] n_en   [NB];
        logic [31:0] n_mode [NB];
        logic        n_irq  [NB];
        for (int b = 0; b < NB; b++) begin
            logic [31:0] s, hw, clr, sset;
            s    = src[b*W +: W];
            hw   = (s & ~m_mode[b]) | (s & ~m_prev[b] & m_mode[b]);
            clr  = '0;
            sset = '0;
            n_en[b]   = m_en[b];
            n_mode[b] = m_mode[b];
            if (req_valid && req_write && (int'(req_addr) / 40) == b) begin
                case (int'(req_addr) % 40)
                    'h00: clr = req_wdata;
                    'h08: n_en[b] = req_wdata;
                    'h18: sset = req_wdata;
                    'h20: n_mode[b] = req_wdata;
                    default: ;
                endcase
            end
            n_stat[b] = (m_stat[b] & ~clr) | hw | sset;
            n_irq[b]  = |(m_stat[b] & m_en[b]);
        end
        @(posedge clk);
        @(negedge clk);
        for (int b = 0; b < NB; b++) begin
            m_stat[b] = n_stat[b];
            m_en[b]   = n_en[b];
            m_mode[b] = n_mode[b];
            m_prev[b] = src[b*W +: W];
            m_irq[b]  = n_irq[b];
            check(irq[b] === m_irq[b], "R10", 32'(irq[b]), 32'(m_irq[b]));
        end
        check(req_ready === 1'b1, "R12", 32'(req_ready), 32'h1);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        cyc();
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        logic [31:0] exp;
        exp = model_read(a);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        cyc();
        req_valid = 1'b0;
        check(rsp_valid === 1'b1, "R12", 32'(rsp_valid), 32'h1);
        check(rsp_rdata === exp, tag_for(a), rsp_rdata, exp);
        d = rsp_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4711));
        rst = 1'b1; src = '0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        for (int b = 0; b < NB; b++) begin
            m_stat[b] = '0; m_en[b] = '0; m_mode[b] = '0; m_prev[b] = '0; m_irq[b] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check(irq === '0, "R1", 32'(irq), 32'h0);
        check(rsp_valid === 1'b0, "R12", 32'(rsp_valid), 32'h0);
        for (int b = 0; b < NB; b++) begin
            rd(8'(b*40 + 'h08), v); check(v === 32'h0, "R1", v, 32'h0);
            rd(8'(b*40 + 'h20), v); check(v === 32'h0, "R1", v, 32'h0);
            rd(8'(b*40 + 'h00), v); check(v === 32'h0, "R1", v, 32'h0);
        end
        idle(1);
        check(rsp_valid === 1'b0, "R12", 32'(rsp_valid), 32'h0);

        // R2: level pulse latches and holds
        wr(8'h08, 32'h0000_0008);
        src[3] = 1'b1; cyc(); src[3] = 1'b0;
        idle(2);
        rd(8'h00, v); check(v === 32'h8, "R2", v, 32'h8);
        check(irq[0] === 1'b1, "R10", 32'(irq[0]), 32'h1);
        rd(8'h10, v); check(v === 32'h8, "R6", v, 32'h8);
        // R6: masked view ignores writes
        wr(8'h10, 32'h0);
        rd(8'h10, v); check(v === 32'h8, "R6", v, 32'h8);
        // R4: clear by ones
        wr(8'h00, 32'hFFFF_FFF7);
        rd(8'h00, v); check(v === 32'h8, "R4", v, 32'h8);
        wr(8'h00, 32'h0000_0008);
        rd(8'h00, v); check(v === 32'h0, "R4", v, 32'h0);
        idle(2);
        check(irq[0] === 1'b0, "R10", 32'(irq[0]), 32'h0);

        // R3: edge mode, input held across a clear
        wr(8'h70, 32'h0000_0020);
        rd(8'h70, v); check(v === 32'h20, "R8", v, 32'h20);
        src[2*W + 5] = 1'b1;
        idle(2);
        rd(8'h50, v); check(v === 32'h20, "R3", v, 32'h20);
        wr(8'h50, 32'h0000_0020);
        idle(2);
        rd(8'h50, v); check(v === 32'h0, "R3", v, 32'h0);
        src[2*W + 5] = 1'b0;
        idle(1);

        // R5: level set vs same-cycle clear
        src[1*W + 0] = 1'b1;
        idle(1);
        wr(8'h28, 32'h0000_0001);
        src[1*W + 0] = 1'b0;
        rd(8'h28, v); check(v === 32'h1, "R5", v, 32'h1);
        wr(8'h28, 32'h0000_0001);
        rd(8'h28, v); check(v === 32'h0, "R5", v, 32'h0);

        // R7 / R9: software set in bank 4 reaches irq_o[4] only
        wr(8'hA8, 32'h8000_0000);
        wr(8'hB8, 32'h8000_0000);
        idle(1);
        check(irq === 5'b10000, "R9", 32'(irq), 32'h10);
        rd(8'hB8, v); check(v === 32'h8000_0000, "R7", v, 32'h8000_0000);
        rd(8'hA0, v); check(v === 32'h8000_0000, "R9", v, 32'h8000_0000);
        wr(8'hA0, 32'hFFFF_FFFF);

        // R11: unmapped addresses
        wr(8'hC8, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'hC8, v); check(v === 32'h0, "R11", v, 32'h0);
        rd(8'h04, v); check(v === 32'h0, "R11", v, 32'h0);
        rd(8'h08, v); check(v === 32'h8, "R11", v, 32'h8);
        rd(8'h00, v); check(v === 32'h0, "R11", v, 32'h0);

        // random phase against the model
        for (int it = 0; it < 600; it++) begin
            int op, bk, oi;
            logic [7:0] a;
            for (int b = 0; b < NB; b++)
                src[b*W +: W] = ($urandom % 4 == 0) ? ($urandom & $urandom & $urandom) : '0;
            op = $urandom % 3;
            bk = $urandom % (NB + 1);
            oi = $urandom % 7;
            case (oi)
                0: a = 8'(bk*40 + 'h00);
                1: a = 8'(bk*40 + 'h08);
                2: a = 8'(bk*40 + 'h10);
                3: a = 8'(bk*40 + 'h18);
                4: a = 8'(bk*40 + 'h20);
                5: a = 8'(bk*40 + 'h04);
                default: a = 8'(bk*40 + 'h24);
            endcase
            if (op == 0) idle(1);
            else if (op == 1) rd(a, v);
            else if (oi == 3) wr(a, $urandom & $urandom);
            else wr(a, $urandom);
        end
        src = '0;
        idle(2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule